// File: doc/BRIEF.md
# Multi-Line Atomic Lock Tracker

This block sits next to a first-level cache controller and keeps track of the cache lines held by one atomic read-modify-write. A single atomic can touch up to `NUM_SLOTS` lines. The block watches the core request stream.

- Atomic requests claim line addresses in a small lock table.
- A start pulse with the first line's address tells the block that the atomic operation is now being serviced.
- Release pulses hand the lines back one at a time. The table empties when the last one is returned.
- A non-atomic core request abandons any partly built lock set.

While the operation is being serviced, every forwarded coherence request from another cache is compared with the held lines. A hit raises `postpone`, which holds the forwarded message in its queue until the lines are released.

The control is a three-state machine:

- **IDLE**: no line is held.
- **ARMED**: the first line is held, but servicing has not started.
- **SERVICING**: the atomic is in progress.

Transitions:

- *claim_first*: IDLE to ARMED, on an atomic request into the empty table.
- *start*: ARMED to SERVICING, on a start pulse whose address matches the first line.
- *abandon*: ARMED or SERVICING to IDLE, on a non-atomic core request.
- *drain*: SERVICING to IDLE, on the release that brings the count to zero.
- *extend*: SERVICING to itself, on an atomic request that claims an extra line.

A protocol violation sets a sticky `error` output. The offending operation then changes nothing else.

Within one cycle, the inputs are applied in a fixed order: the core request first, then the start pulse, then the release pulse. Each sees the result of the one before it.

Top module: `atomic_lock_tracker`

## Requirements
- R1: After reset no line is held, `servicing` is 0, `lock_count` is 0, `error` is 0 and `postpone` is 0.
- R2: An atomic core request into an empty table claims the first slot and `lock_count` becomes 1. A further atomic request to the same address changes nothing.
- R3: While not servicing with the first slot held, an atomic request to a different address sets `error` and changes nothing else.
- R4: While servicing, an atomic request whose address differs from the first slot claims the lowest free slot among slots 2..NUM_SLOTS and increments `lock_count`. An atomic request equal to the first slot changes nothing.
- R5: While servicing, an atomic request that needs a slot beyond NUM_SLOTS sets `error` and claims nothing.
- R6: Claiming slot k (1-based, k >= 2) needs `lock_count` equal to k-1. Otherwise `error` is set and nothing is claimed (for example after a partial release).
- R7: A non-atomic core request while the first slot is held empties every slot, zeroes `lock_count` and clears `servicing`. On an empty table it has no effect.
- R8: A start pulse when not servicing sets `servicing` if its address equals the held first slot. If it does not match, or the table is empty, it sets `error` and changes nothing. While already servicing, it has no effect.
- R9: A release pulse while not servicing sets `error`. While servicing, it decrements `lock_count`. When the count reaches 0, `servicing` clears and all slots empty.
- R10: `postpone` is high in the same cycle exactly when `fwd_valid` is high, `servicing` is set and `fwd_addr` equals a held slot. It uses the state before the clock edge, and an empty slot never matches.
- R11: Once set, `error` stays high until reset.
- R12: In one cycle the core request is applied first, then the start pulse, then the release pulse. Each acts on the state left by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request present this cycle |
| core_req_atomic | input | 1 | Core request is atomic (1) or ordinary (0) |
| core_req_addr | input | ADDR_W | Line address of the core request |
| set_valid | input | 1 | Start-of-atomic pulse |
| set_addr | input | ADDR_W | Line address carried by the start pulse |
| clr_pulse | input | 1 | Release one locked line |
| fwd_valid | input | 1 | Forwarded coherence request present |
| fwd_addr | input | ADDR_W | Line address of the forwarded request |
| postpone | output | 1 | Forwarded request hits a locked line and must wait |
| servicing | output | 1 | Atomic operation in progress |
| lock_count | output | $clog2(NUM_SLOTS+1) | Number of lines still to be released |
| error | output | 1 | Sticky protocol violation flag |

## Verification
Two functions often meet in one cycle:

- the forwarded compare, which reads the state before the edge;
- a start or release pulse, which changes that state at the edge.

The bench provokes this in directed steps. In one step a forwarded request to the first line arrives together with the start pulse, and `postpone` must stay low. In another it arrives with the final release, and `postpone` must still be high. Random steps then drive core, start, release and forwarded traffic together over a five-address pool. Each step is judged against a sequential bench model that applies core, start and release in that order.

// File: rtl/alt_pkg.sv
`timescale 1ns/1ps
package alt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_ARMED     = 2'd1,
        PH_SERVICING = 2'd2
    } lock_phase_e;

endpackage

// File: rtl/alt_slot_table.sv
`timescale 1ns/1ps
module alt_slot_table #(
    parameter int ADDR_W    = 32,
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] wr_sel,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 wipe,
    input  logic [ADDR_W-1:0]    fwd_addr,
    input  logic [ADDR_W-1:0]    core_addr,
    input  logic [ADDR_W-1:0]    set_addr,
    output logic [NUM_SLOTS-1:0] occ,
    output logic [NUM_SLOTS-1:0] fwd_hit,
    output logic                 core_hit_first,
    output logic                 set_hit_first
);

    localparam logic [ADDR_W-1:0] EMPTY_TAG = '1;

    logic [ADDR_W-1:0] slot_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] occ_q;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q[g] <= EMPTY_TAG;
                    occ_q[g]  <= 1'b0;
                end else if (wipe) begin
                    slot_q[g] <= EMPTY_TAG;
                    occ_q[g]  <= 1'b0;
                end else if (wr_sel[g]) begin
                    slot_q[g] <= wr_addr;
                    occ_q[g]  <= 1'b1;
                end
            end

            // the occupancy bit gates every compare, so an empty tag never hits
            assign fwd_hit[g] = occ_q[g] && (slot_q[g] == fwd_addr);
        end
    endgenerate

    assign occ            = occ_q;
    assign core_hit_first = occ_q[0] && (slot_q[0] == core_addr);
    assign set_hit_first  = occ_q[0] && (slot_q[0] == set_addr);

endmodule

// File: rtl/alt_lock_ctrl.sv
`timescale 1ns/1ps
module alt_lock_ctrl
    import alt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 core_valid,
    input  logic                 core_atomic,
    input  logic                 core_hit_first,
    input  logic                 set_valid,
    input  logic                 set_hit_first,
    input  logic                 set_eq_core,
    input  logic                 clr_pulse,
    input  logic [NUM_SLOTS-1:0] occ,
    output logic [NUM_SLOTS-1:0] wr_sel,
    output logic                 wipe,
    output logic                 servicing,
    output logic [CNT_W-1:0]     count,
    output logic                 error
);

    lock_phase_e          phase_q, phase_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic                 err_q, err_d;
    logic [NUM_SLOTS-1:0] fill;
    logic                 clear_all;
    logic                 took_first;
    logic                 free_found;
    int unsigned          free_idx;

    // next-state logic: core request, then start pulse, then release pulse
    always_comb begin
        phase_d    = phase_q;
        cnt_d      = cnt_q;
        err_d      = err_q;
        fill       = '0;
        clear_all  = 1'b0;
        took_first = 1'b0;
        free_found = 1'b0;
        free_idx   = 0;

        for (int k = NUM_SLOTS - 1; k >= 1; k--) begin
            if (!occ[k]) begin
                free_found = 1'b1;
                free_idx   = k;
            end
        end

        // stage 1: core request
        if (core_valid) begin
            if (core_atomic) begin
                unique case (phase_q)
                    PH_IDLE: begin
                        if (cnt_q != '0) begin
                            err_d = 1'b1;
                        end else begin
                            fill[0]    = 1'b1;
                            cnt_d      = cnt_q + CNT_W'(1);
                            phase_d    = PH_ARMED;
                            took_first = 1'b1;
                        end
                    end
                    PH_ARMED: begin
                        if (!core_hit_first) begin
                            err_d = 1'b1;
                        end
                    end
                    PH_SERVICING: begin
                        if (!core_hit_first) begin
                            if (!free_found) begin
                                err_d = 1'b1;
                            end else if (cnt_q != CNT_W'(free_idx)) begin
                                err_d = 1'b1;
                            end else begin
                                fill  = NUM_SLOTS'(1) << free_idx;
                                cnt_d = cnt_q + CNT_W'(1);
                            end
                        end
                    end
                    default: err_d = 1'b1;
                endcase
            end else if (phase_q != PH_IDLE) begin
                clear_all = 1'b1;
                cnt_d     = '0;
                phase_d   = PH_IDLE;
            end
        end

        // stage 2: start pulse
        if (set_valid && (phase_d != PH_SERVICING)) begin
            if (took_first ? set_eq_core
                           : ((phase_d == PH_ARMED) && set_hit_first)) begin
                phase_d = PH_SERVICING;
            end else begin
                err_d = 1'b1;
            end
        end

        // stage 3: release pulse
        if (clr_pulse) begin
            if ((phase_d != PH_SERVICING) || (cnt_d == '0)) begin
                err_d = 1'b1;
            end else begin
                cnt_d = cnt_d - CNT_W'(1);
                if (cnt_d == '0) begin
                    clear_all = 1'b1;
                    fill      = '0;
                    phase_d   = PH_IDLE;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            err_q   <= err_d;
        end
    end

    // outputs
    always_comb begin
        wr_sel    = fill;
        wipe      = clear_all;
        servicing = (phase_q == PH_SERVICING);
        count     = cnt_q;
        error     = err_q;
    end

endmodule

// File: rtl/alt_fwd_match.sv
`timescale 1ns/1ps
module alt_fwd_match #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 fwd_valid,
    input  logic                 servicing,
    input  logic [NUM_SLOTS-1:0] fwd_hit,
    output logic                 postpone
);

    always_comb begin
        postpone = fwd_valid && servicing && (|fwd_hit);
    end

endmodule

// File: rtl/atomic_lock_tracker.sv
`timescale 1ns/1ps
module atomic_lock_tracker #(
    parameter int ADDR_W    = 32,
    parameter int NUM_SLOTS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               core_req_valid,
    input  logic                               core_req_atomic,
    input  logic [ADDR_W-1:0]                  core_req_addr,
    input  logic                               set_valid,
    input  logic [ADDR_W-1:0]                  set_addr,
    input  logic                               clr_pulse,
    input  logic                               fwd_valid,
    input  logic [ADDR_W-1:0]                  fwd_addr,
    output logic                               postpone,
    output logic                               servicing,
    output logic [$clog2(NUM_SLOTS+1)-1:0]     lock_count,
    output logic                               error
);

    localparam int CNT_W = $clog2(NUM_SLOTS + 1);

    logic [NUM_SLOTS-1:0] wr_sel;
    logic                 wipe;
    logic [NUM_SLOTS-1:0] occ;
    logic [NUM_SLOTS-1:0] fwd_hit;
    logic                 core_hit_first;
    logic                 set_hit_first;
    logic                 set_eq_core;
    logic                 serv_int;

    assign set_eq_core = (set_addr == core_req_addr);

    alt_slot_table #(
        .ADDR_W    (ADDR_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_table (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_sel         (wr_sel),
        .wr_addr        (core_req_addr),
        .wipe           (wipe),
        .fwd_addr       (fwd_addr),
        .core_addr      (core_req_addr),
        .set_addr       (set_addr),
        .occ            (occ),
        .fwd_hit        (fwd_hit),
        .core_hit_first (core_hit_first),
        .set_hit_first  (set_hit_first)
    );

    alt_lock_ctrl #(
        .NUM_SLOTS (NUM_SLOTS),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .core_valid     (core_req_valid),
        .core_atomic    (core_req_atomic),
        .core_hit_first (core_hit_first),
        .set_valid      (set_valid),
        .set_hit_first  (set_hit_first),
        .set_eq_core    (set_eq_core),
        .clr_pulse      (clr_pulse),
        .occ            (occ),
        .wr_sel         (wr_sel),
        .wipe           (wipe),
        .servicing      (serv_int),
        .count          (lock_count),
        .error          (error)
    );

    alt_fwd_match #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_fwd (
        .fwd_valid (fwd_valid),
        .servicing (serv_int),
        .fwd_hit   (fwd_hit),
        .postpone  (postpone)
    );

    assign servicing = serv_int;

endmodule

// File: rtl/alt_lock_checker.sv
`timescale 1ns/1ps
module alt_lock_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_req_valid,
    input logic             core_req_atomic,
    input logic             set_valid,
    input logic             clr_pulse,
    input logic             fwd_valid,
    input logic             postpone,
    input logic             servicing,
    input logic [CNT_W-1:0] lock_count,
    input logic             error
);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    // R10
    postpone_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        postpone |-> (servicing && fwd_valid));

    // R9
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && !servicing && !set_valid && !core_req_valid) |=> error);

    // R9
    serv_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        servicing |-> (lock_count != '0));

    // R7
    abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_valid && !core_req_atomic && !set_valid)
            |=> ((lock_count == '0) && !servicing));

    // R8
    serv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(servicing) |-> $past(set_valid));

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_count <= CNT_W'(NUM_SLOTS));

endmodule

bind atomic_lock_tracker alt_lock_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     ($clog2(NUM_SLOTS + 1))
) u_lock_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .core_req_valid  (core_req_valid),
    .core_req_atomic (core_req_atomic),
    .set_valid       (set_valid),
    .clr_pulse       (clr_pulse),
    .fwd_valid       (fwd_valid),
    .postpone        (postpone),
    .servicing       (servicing),
    .lock_count      (lock_count),
    .error           (error)
);

// File: tb/test_atomic_lock_tracker.sv
`timescale 1ns/1ps
module test_atomic_lock_tracker;

    localparam int AW = 32;
    localparam int NS = 4;
    localparam int CW = $clog2(NS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_req_valid = 1'b0;
    logic          core_req_atomic = 1'b0;
    logic [AW-1:0] core_req_addr = '0;
    logic          set_valid = 1'b0;
    logic [AW-1:0] set_addr = '0;
    logic          clr_pulse = 1'b0;
    logic          fwd_valid = 1'b0;
    logic [AW-1:0] fwd_addr = '0;
    logic          postpone;
    logic          servicing;
    logic [CW-1:0] lock_count;
    logic          error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench reference model
    logic [AW-1:0] m_slot [NS];
    bit            m_occ  [NS];
    int            m_cnt;
    bit            m_serv;
    bit            m_err;

    always #4 clk = ~clk;   // 125 MHz

    atomic_lock_tracker #(.ADDR_W(AW), .NUM_SLOTS(NS)) i_atomic_lock_tracker (
        .clk             (clk),
        .rst_n           (rst_n),
        .core_req_valid  (core_req_valid),
        .core_req_atomic (core_req_atomic),
        .core_req_addr   (core_req_addr),
        .set_valid       (set_valid),
        .set_addr        (set_addr),
        .clr_pulse       (clr_pulse),
        .fwd_valid       (fwd_valid),
        .fwd_addr        (fwd_addr),
        .postpone        (postpone),
        .servicing       (servicing),
        .lock_count      (lock_count),
        .error           (error)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_slot[i] = '1;
            m_occ[i]  = 1'b0;
        end
        m_cnt  = 0;
        m_serv = 1'b0;
        m_err  = 1'b0;
    endtask

    task automatic model_empty();
        for (int i = 0; i < NS; i++) begin
            m_slot[i] = '1;
            m_occ[i]  = 1'b0;
        end
        m_cnt  = 0;
        m_serv = 1'b0;
    endtask

    function automatic bit model_postpone(bit fv, logic [AW-1:0] fa);
        bit hit = 1'b0;
        for (int i = 0; i < NS; i++)
            if (m_occ[i] && m_slot[i] == fa) hit = 1'b1;
        return fv && m_serv && hit;
    endfunction

    // applies core, then start, then release, in sequence (R12)
    task automatic model_step(bit cv, bit ca, logic [AW-1:0] cadr,
                              bit sv, logic [AW-1:0] sadr, bit cl);
        int k;
        if (cv) begin
            if (ca) begin
                if (!m_serv) begin
                    if (!m_occ[0]) begin
                        m_slot[0] = cadr; m_occ[0] = 1'b1; m_cnt++;
                    end else if (m_slot[0] != cadr) begin
                        m_err = 1'b1;
                    end
                end else if (m_slot[0] != cadr) begin
                    k = -1;
                    for (int i = 1; i < NS; i++)
                        if (!m_occ[i] && k < 0) k = i;
                    if (k < 0 || m_cnt != k) m_err = 1'b1;
                    else begin
                        m_slot[k] = cadr; m_occ[k] = 1'b1; m_cnt++;
                    end
                end
            end else if (m_occ[0]) begin
                model_empty();
            end
        end
        if (sv && !m_serv) begin
            if (m_occ[0] && m_slot[0] == sadr) m_serv = 1'b1;
            else m_err = 1'b1;
        end
        if (cl) begin
            if (!m_serv) m_err = 1'b1;
            else begin
                m_cnt--;
                if (m_cnt == 0) model_empty();
            end
        end
    endtask

    // one cycle: drive at negedge, check postpone, clock, check state
    task automatic step(string req, bit cv, bit ca, logic [AW-1:0] cadr,
                        bit sv, logic [AW-1:0] sadr, bit cl,
                        bit fv, logic [AW-1:0] fa);
        core_req_valid  = cv;
        core_req_atomic = ca;
        core_req_addr   = cadr;
        set_valid       = sv;
        set_addr        = sadr;
        clr_pulse       = cl;
        fwd_valid       = fv;
        fwd_addr        = fa;
        #1;
        chk({req, " R10 postpone"}, 32'(postpone), 32'(model_postpone(fv, fa)));
        @(posedge clk);
        model_step(cv, ca, cadr, sv, sadr, cl);
        @(negedge clk);
        chk({req, " servicing"}, 32'(servicing), 32'(m_serv));
        chk({req, " lock_count"}, 32'(lock_count), 32'(m_cnt));
        chk({req, " error"}, 32'(error), 32'(m_err));
        core_req_valid = 1'b0;
        set_valid      = 1'b0;
        clr_pulse      = 1'b0;
        fwd_valid      = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        #1;
        chk("R1 servicing", 32'(servicing), 32'd0);
        chk("R1 lock_count", 32'(lock_count), 32'd0);
        chk("R1 error", 32'(error), 32'd0);
    endtask

    task automatic idle(string req, bit fv, logic [AW-1:0] fa);
        step(req, 0, 0, '0, 0, '0, 0, fv, fa);
    endtask

    localparam logic [AW-1:0] A = 32'h0000_1040;
    localparam logic [AW-1:0] B = 32'h0000_2080;
    localparam logic [AW-1:0] C = 32'h0000_30C0;
    localparam logic [AW-1:0] D = 32'h0000_4100;
    localparam logic [AW-1:0] E = 32'h0000_5140;

    initial begin
        logic [AW-1:0] pool [5];
        pool[0] = A; pool[1] = B; pool[2] = C; pool[3] = D; pool[4] = E;
        void'($urandom(32'h5EED_0A7C));
        model_reset();
        do_reset();
        idle("R1 fwd", 1, '1);

        // R2 first claim and repeat
        step("R2 claim", 1, 1, A, 0, '0, 0, 0, '0);
        step("R2 repeat", 1, 1, A, 0, '0, 0, 0, '0);
        // R3 different atomic while armed
        step("R3 mismatch", 1, 1, B, 0, '0, 0, 0, '0);
        do_reset();

        // R8 start, R10 postpone, R4 extend, R5 overflow
        step("R2 claim", 1, 1, A, 0, '0, 0, 0, '0);
        step("R8 start fwd same cycle", 0, 0, '0, 1, A, 0, 1, A);
        idle("R10 hit first", 1, A);
        step("R4 same addr", 1, 1, A, 0, '0, 0, 0, '0);
        step("R4 slot2", 1, 1, B, 0, '0, 0, 0, '0);
        step("R4 slot3", 1, 1, C, 0, '0, 0, 1, B);
        step("R4 slot4", 1, 1, D, 0, '0, 0, 0, '0);
        idle("R10 hit last", 1, D);
        idle("R10 miss", 1, E);
        step("R8 start while servicing", 0, 0, '0, 1, E, 0, 0, '0);
        step("R5 fifth line", 1, 1, E, 0, '0, 0, 1, E);
        do_reset();

        // R6 count mismatch after partial release
        step("R2 claim", 1, 1, A, 0, '0, 0, 0, '0);
        step("R8 start", 0, 0, '0, 1, A, 0, 0, '0);
        step("R4 slot2", 1, 1, B, 0, '0, 0, 0, '0);
        step("R9 partial release", 0, 0, '0, 0, '0, 1, 1, B);
        step("R6 mismatch", 1, 1, C, 0, '0, 0, 0, '0);
        do_reset();

        // R9 full drain, fwd on the final release cycle still postponed
        step("R2 claim", 1, 1, A, 0, '0, 0, 0, '0);
        step("R8 start", 0, 0, '0, 1, A, 0, 0, '0);
        step("R4 slot2", 1, 1, B, 0, '0, 0, 0, '0);
        step("R9 release", 0, 0, '0, 0, '0, 1, 0, '0);
        step("R9 final release", 0, 0, '0, 0, '0, 1, 1, A);
        idle("R9 released", 1, A);
        step("R9 release idle", 0, 0, '0, 0, '0, 1, 0, '0);
        do_reset();

        // R7 abandon and no-op on empty
        step("R7 empty nonatomic", 1, 0, C, 0, '0, 0, 0, '0);
        step("R2 claim", 1, 1, A, 0, '0, 0, 0, '0);
        step("R8 start", 0, 0, '0, 1, A, 0, 0, '0);
        step("R7 abandon", 1, 0, C, 0, '0, 0, 1, A);
        idle("R7 after abandon", 1, A);
        // R8 start on empty table
        step("R8 start empty", 0, 0, '0, 1, A, 0, 0, '0);
        // R11 error sticky
        repeat (5) idle("R11 sticky", 0, '0);
        do_reset();

        // R8 start mismatch
        step("R2 claim", 1, 1, B, 0, '0, 0, 0, '0);
        step("R8 start mismatch", 0, 0, '0, 1, C, 0, 0, '0);
        do_reset();

        // R12 claim, start and release in one cycle
        step("R12 claim+start", 1, 1, C, 1, C, 0, 1, C);
        idle("R12 postpone", 1, C);
        do_reset();
        step("R12 claim+start+release", 1, 1, D, 1, D, 1, 0, '0);
        idle("R12 drained", 1, D);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            if (n % 150 == 149) do_reset();
            step("R12 random",
                 ($urandom % 2) == 0, ($urandom % 4) != 0, pool[$urandom % 5],
                 ($urandom % 5) == 0, pool[$urandom % 5],
                 ($urandom % 6) == 0,
                 ($urandom % 2) == 0, pool[$urandom % 5]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule